// File: doc/BRIEF.md
# I2C Target Byte Port Expander

This block is a target on a two-wire I2C bus that exposes a single 8-bit parallel port. It has no register pointer and no subaddress. The one data byte that a controller writes is the port output value. The one byte that a controller reads is a capture of the port pins. SCL and SDA are oversampled with the system clock. Each line passes through a two-flop synchronizer and then a three-tap majority vote, so the logic tracks the bus with a short fixed delay.

A transfer starts with START. The controller then sends a 7-bit address and a direction bit. The upper four address bits are fixed at binary 0100 and the low three come from strap inputs, which are captured at START. The block acknowledges a matching address by pulling SDA low. In a write transfer, the first data byte is acknowledged and loaded into the port register, and any later bytes are ignored. In a read transfer, the block shifts out a fresh capture of the pins before every byte that the controller acknowledges.

The block emits a one-cycle pulse each time the port register is loaded and each time the pins are captured, so neighbouring interrupt logic can use them. SDA is driven only as an open-drain enable.

Top module: `i2c_port_expander`

## Requirements
- R1: While and after reset, `port_o` is 0xFF, `sda_oe_o` is 0, and both strobes are 0.
- R2: The first byte after START is decoded MSB first as address bits [7:1] and a direction bit in bit 0 (0 = write, 1 = read). Address bits [7:4] must equal 0100 and bits [3:1] must equal the captured straps. On a match, the block holds SDA low for the entire high phase of the ninth clock.
- R3: A non-matching address, including the general call byte 0x00, is not acknowledged. The transfer that follows leaves `port_o` unchanged and produces no write strobe.
- R4: In a write transfer, the first data byte is acknowledged. `port_o` takes that byte after the rising SCL edge of its acknowledge clock, and `wr_strobe_o` pulses exactly once.
- R5: In a write transfer, every data byte after the first gets no acknowledge and does not change `port_o`.
- R6: In a read transfer, each byte is the pin state captured when that byte begins, sent bit 7 first. `rd_strobe_o` pulses once per capture. After a controller acknowledge, a new capture is sent.
- R7: After a controller NACK on a read, SDA is released and stays released until the next START.
- R8: A STOP or START that arrives partway through a byte abandons the transfer. The partial byte is dropped and `port_o` keeps its previous value.
- R9: The strap inputs are captured at START. A change to them after START does not affect address matching for that transfer.
- R10: An SDA pulse one system clock long is filtered out and is not taken as a START.
- R11: Each strobe is high for exactly one system clock per event, and the two strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| strap_i | input | 3 | Low three address bits |
| pin_i | input | 8 | Current port pin levels |
| port_o | output | 8 | Port output register |
| wr_strobe_o | output | 1 | One-cycle pulse when `port_o` is loaded |
| rd_strobe_o | output | 1 | One-cycle pulse when the pins are captured |

## Verification
The bench targets the following corner cases:

- **Extra write bytes.** A design that loaded every write byte would show the second byte on the port and acknowledge it.
- **Per-byte capture on reads.** One that captured the pins only once per read would return the old value in the second byte after the pins changed.
- **Aborts.** Aborts are driven with both STOP and repeated START partway through a byte. A design that committed partial data, or whose bit counter did not clear, would corrupt `port_o` or miss the next address.
- **Strap timing and glitches.** A strap change after START, and a one-clock SDA glitch while idle, check that the address is not taken from live straps and that a noise pulse does not open a transfer.

// File: rtl/pxp_pkg.sv
package pxp_pkg;

  localparam int BYTE_W  = 8;
  localparam int STRAP_W = 3;
  localparam int CNT_W   = $clog2(BYTE_W);
  localparam logic [BYTE_W-2-STRAP_W:0] ADDR_HI = 4'b0100;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDATA,
    ST_WACK,
    ST_WSKIP,
    ST_RDATA,
    ST_RACK
  } pxp_state_e;

endpackage

// File: rtl/pxp_line_filter.sv
module pxp_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int VOTE_TAPS   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);

  localparam int CW = $clog2(VOTE_TAPS + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [VOTE_TAPS-1:0]   tap_q;
  logic [CW-1:0]          ones;
  logic                   vote_d;

  // count of high taps, majority decides
  always_comb begin
    ones = '0;
    for (int i = 0; i < VOTE_TAPS; i++) begin
      ones = ones + {{(CW-1){1'b0}}, tap_q[i]};
    end
    vote_d = (ones > CW'(VOTE_TAPS / 2));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      tap_q  <= '1;
      line_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      tap_q  <= {tap_q[VOTE_TAPS-2:0], sync_q[SYNC_STAGES-1]};
      line_o <= vote_d;
    end
  end

endmodule

// File: rtl/pxp_bus_events.sv
module pxp_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  always_comb begin
    scl_rise = scl_f & ~scl_q;
    scl_fall = ~scl_f & scl_q;
    start_ev = scl_f & scl_q & sda_q & ~sda_f;
    stop_ev  = scl_f & scl_q & ~sda_q & sda_f;
  end

endmodule

// File: rtl/pxp_link_fsm.sv
module pxp_link_fsm
  import pxp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_ev,
  input  logic               stop_ev,
  input  logic               sda_f,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [BYTE_W-1:0]  pin_i,
  output logic [BYTE_W-1:0]  port_o,
  output logic               sda_oe_o,
  output logic               wr_strobe_o,
  output logic               rd_strobe_o
);

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  pxp_state_e          state_q, state_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic                full_q, full_d;
  logic [BYTE_W-1:0]   sh_q, sh_d;
  logic [BYTE_W-1:0]   port_q, port_d;
  logic [STRAP_W-1:0]  strap_q, strap_d;
  logic                mack_q, mack_d;
  logic                wr_q, wr_d;
  logic                rd_q, rd_d;
  logic                addr_hit;

  assign addr_hit = (sh_q[BYTE_W-1:1] == {ADDR_HI, strap_q});

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    full_d  = full_q;
    sh_d    = sh_q;
    port_d  = port_q;
    strap_d = strap_q;
    mack_d  = mack_q;
    wr_d    = 1'b0;
    rd_d    = 1'b0;
    if (stop_ev) begin
      state_d = ST_IDLE;
      full_d  = 1'b0;
      cnt_d   = '0;
    end else if (start_ev) begin
      state_d = ST_ADDR;
      full_d  = 1'b0;
      cnt_d   = '0;
      strap_d = strap_i;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_WDATA: begin
          if (scl_rise) begin
            sh_d   = {sh_q[BYTE_W-2:0], sda_f};
            cnt_d  = cnt_q + 1'b1;
            full_d = (cnt_q == LAST_BIT);
          end else if (scl_fall && full_q) begin
            full_d = 1'b0;
            cnt_d  = '0;
            if (state_q == ST_WDATA) begin
              state_d = ST_WACK;
            end else if (addr_hit) begin
              state_d = ST_AACK;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            if (sh_q[0]) begin
              state_d = ST_RDATA;
              sh_d    = pin_i;
              rd_d    = 1'b1;
            end else begin
              state_d = ST_WDATA;
            end
          end
        end
        ST_WACK: begin
          if (scl_rise) begin
            port_d = sh_q;
            wr_d   = 1'b1;
          end else if (scl_fall) begin
            state_d = ST_WSKIP;
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (cnt_q == LAST_BIT) begin
              state_d = ST_RACK;
              cnt_d   = '0;
              mack_d  = 1'b0;
            end else begin
              sh_d  = {sh_q[BYTE_W-2:0], 1'b1};
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_d = ~sda_f;
          end else if (scl_fall) begin
            if (mack_q) begin
              state_d = ST_RDATA;
              sh_d    = pin_i;
              rd_d    = 1'b1;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      full_q  <= 1'b0;
      sh_q    <= '1;
      port_q  <= '1;
      strap_q <= '0;
      mack_q  <= 1'b0;
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      full_q  <= full_d;
      sh_q    <= sh_d;
      port_q  <= port_d;
      strap_q <= strap_d;
      mack_q  <= mack_d;
      wr_q    <= wr_d;
      rd_q    <= rd_d;
    end
  end

  assign port_o      = port_q;
  assign wr_strobe_o = wr_q;
  assign rd_strobe_o = rd_q;
  assign sda_oe_o    = (state_q == ST_AACK) || (state_q == ST_WACK) ||
                       ((state_q == ST_RDATA) && !sh_q[BYTE_W-1]);

endmodule

// File: rtl/i2c_port_expander.sv
module i2c_port_expander #(
  parameter int SYNC_STAGES = 2,
  parameter int VOTE_TAPS   = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [2:0] strap_i,
  input  logic [7:0] pin_i,
  output logic [7:0] port_o,
  output logic       wr_strobe_o,
  output logic       rd_strobe_o
);

  localparam int LINES = 2;

  logic [1:0]       rst_pipe;
  logic             rst_int_n;
  logic [LINES-1:0] raw_lines;
  logic [LINES-1:0] filt_lines;
  logic             scl_f;
  logic             sda_f;
  logic             scl_rise;
  logic             scl_fall;
  logic             start_ev;
  logic             stop_ev;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    pxp_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .VOTE_TAPS  (VOTE_TAPS)
    ) u_filt (
      .clk   (clk),
      .rst_n (rst_int_n),
      .line_i(raw_lines[g]),
      .line_o(filt_lines[g])
    );
  end

  assign scl_f = filt_lines[0];
  assign sda_f = filt_lines[1];

  pxp_bus_events u_events (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .scl_f   (scl_f),
    .sda_f   (sda_f),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .start_ev(start_ev),
    .stop_ev (stop_ev)
  );

  pxp_link_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_ev   (start_ev),
    .stop_ev    (stop_ev),
    .sda_f      (sda_f),
    .strap_i    (strap_i),
    .pin_i      (pin_i),
    .port_o     (port_o),
    .sda_oe_o   (sda_oe_o),
    .wr_strobe_o(wr_strobe_o),
    .rd_strobe_o(rd_strobe_o)
  );

endmodule

// File: rtl/pxp_checker.sv
module pxp_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_f,
  input logic       sda_oe_o,
  input logic [7:0] port_o,
  input logic       wr_strobe_o,
  input logic       rd_strobe_o
);

  // R2: the SDA drive only moves while filtered SCL is low
  assert_oe_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !scl_f);

  // R4 / R8: the port register moves only together with a write strobe
  assert_port_needs_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(port_o) |-> wr_strobe_o);

  // R11: write strobe lasts one cycle
  assert_wr_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe_o |=> !wr_strobe_o);

  // R11: read strobe lasts one cycle
  assert_rd_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe_o |=> !rd_strobe_o);

  // R11: strobes never coincide
  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_strobe_o && rd_strobe_o));

  // R6: a capture is taken at an SCL fall, so SCL is low at the strobe
  assert_rd_at_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe_o |-> !scl_f);

endmodule

bind i2c_port_expander pxp_checker u_pxp_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_f      (scl_f),
  .sda_oe_o   (sda_oe_o),
  .port_o     (port_o),
  .wr_strobe_o(wr_strobe_o),
  .rd_strobe_o(rd_strobe_o)
);

// File: tb/i2c_port_expander_tb_top.sv
`timescale 1ns/1ps
module i2c_port_expander_tb_top;

  localparam int Q = 10;
  localparam int NV = 7;
  // {strap[2:0], addr byte[7:0], data[7:0], expect_ack}
  localparam logic [19:0] VEC [0:NV-1] = '{
    {3'd0, 8'h40, 8'h5A, 1'b1},
    {3'd7, 8'h4E, 8'h00, 1'b1},
    {3'd5, 8'h4A, 8'hC3, 1'b1},
    {3'd5, 8'h4C, 8'h11, 1'b0},
    {3'd2, 8'h00, 8'h22, 1'b0},
    {3'd2, 8'h44, 8'hFF, 1'b1},
    {3'd3, 8'h86, 8'h33, 1'b0}
  };

  logic       clk;
  logic       rst_n;
  logic       scl_m;
  logic       sda_m;
  logic       sda_line;
  logic       sda_oe_o;
  logic [2:0] strap_i;
  logic [7:0] pin_i;
  logic [7:0] port_o;
  logic       wr_strobe_o;
  logic       rd_strobe_o;

  int checks = 0;
  int fails  = 0;
  int wr_cnt = 0;
  int rd_cnt = 0;
  logic [7:0] exp_port;

  assign sda_line = sda_m & ~sda_oe_o;

  i2c_port_expander dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_m),
    .sda_i      (sda_line),
    .sda_oe_o   (sda_oe_o),
    .strap_i    (strap_i),
    .pin_i      (pin_i),
    .port_o     (port_o),
    .wr_strobe_o(wr_strobe_o),
    .rd_strobe_o(rd_strobe_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_strobe_o) wr_cnt++;
      if (rd_strobe_o) rd_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wq(Q);
      scl_m = 1'b1; wq(2*Q);
      scl_m = 1'b0; wq(Q);
    end
  endtask

  // returns 1 when SDA is held low through the whole ninth high phase
  task automatic send_byte(input logic [7:0] b, output bit acked);
    logic s_early, s_late;
    send_bits(b, 8);
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q/2);
    s_early = sda_line;
    wq(2*Q - Q/2 - 1);
    s_late = sda_line;
    wq(1);
    scl_m = 1'b0; wq(Q);
    acked = (s_early == 1'b0) && (s_late == 1'b0);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q);
      scl_m = 1'b1; wq(Q);
      b[i] = sda_line; wq(Q);
      scl_m = 1'b0; wq(Q);
    end
    sda_m = ~give_ack; wq(Q);
    scl_m = 1'b1; wq(2*Q);
    scl_m = 1'b0; wq(Q);
    sda_m = 1'b1;
  endtask

  initial begin
    bit         ack;
    logic [7:0] rb;
    int         w0;
    int         r0;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; strap_i = 3'd0; pin_i = 8'hA5;
    wq(3);
    // R1: reset values during reset
    chk(port_o == 8'hFF && !sda_oe_o && !wr_strobe_o && !rd_strobe_o, "R1 in reset",
        {sda_oe_o, port_o}, 8'hFF);
    rst_n = 1'b1;
    wq(10);
    chk(port_o == 8'hFF && !sda_oe_o, "R1 after reset", {sda_oe_o, port_o}, 8'hFF);
    exp_port = 8'hFF;

    // table walk: R2 match/ack, R3 mismatch and general call, R4 port load
    for (int v = 0; v < NV; v++) begin
      strap_i = VEC[v][19:17];
      w0 = wr_cnt;
      bus_start();
      send_byte(VEC[v][16:9], ack);
      chk(ack == VEC[v][0], VEC[v][0] ? "R2 address ack" : "R3 address nack",
          ack, VEC[v][0]);
      send_byte(VEC[v][8:1], ack);
      if (VEC[v][0]) exp_port = VEC[v][8:1];
      chk(ack == VEC[v][0], "R4 data ack", ack, VEC[v][0]);
      chk(port_o == exp_port, VEC[v][0] ? "R4 port value" : "R3 port unchanged",
          port_o, exp_port);
      chk(wr_cnt - w0 == (VEC[v][0] ? 1 : 0), "R4 write strobe count",
          wr_cnt - w0, VEC[v][0]);
      bus_stop();
    end

    // R5: second data byte ignored
    strap_i = 3'd1;
    bus_start();
    send_byte(8'h42, ack);
    send_byte(8'h96, ack);
    chk(ack == 1'b1, "R4 first byte ack", ack, 1);
    w0 = wr_cnt;
    send_byte(8'h0F, ack);
    chk(ack == 1'b0, "R5 extra byte nack", ack, 0);
    chk(port_o == 8'h96 && wr_cnt == w0, "R5 port kept", port_o, 8'h96);
    bus_stop();
    exp_port = 8'h96;

    // R6: read returns captures, fresh one after controller ack
    pin_i = 8'hA5;
    r0 = rd_cnt;
    bus_start();
    send_byte(8'h43, ack);
    chk(ack == 1'b1, "R2 read address ack", ack, 1);
    pin_i = 8'h3C;
    recv_byte(1'b1, rb);
    chk(rb == 8'hA5, "R6 first read byte", rb, 8'hA5);
    pin_i = 8'h81;
    recv_byte(1'b0, rb);
    chk(rb == 8'h3C, "R6 fresh capture", rb, 8'h3C);
    chk(rd_cnt - r0 == 2, "R6 read strobe count", rd_cnt - r0, 2);
    // R7: after NACK the block leaves SDA released
    recv_byte(1'b0, rb);
    chk(rb == 8'hFF && !sda_oe_o, "R7 released after nack", rb, 8'hFF);
    bus_stop();

    // R8: STOP partway through a data byte
    bus_start();
    send_byte(8'h42, ack);
    send_bits(8'h00, 4);
    bus_stop();
    chk(port_o == exp_port, "R8 stop abort keeps port", port_o, exp_port);
    // R8: repeated START partway through, then a clean write
    bus_start();
    send_byte(8'h42, ack);
    send_bits(8'h11, 5);
    bus_start();
    chk(port_o == exp_port, "R8 restart abort keeps port", port_o, exp_port);
    send_byte(8'h42, ack);
    chk(ack == 1'b1, "R8 address after restart", ack, 1);
    send_byte(8'h7E, ack);
    exp_port = 8'h7E;
    chk(port_o == exp_port, "R8 write after restart", port_o, exp_port);
    bus_stop();

    // R9: straps captured at START
    strap_i = 3'd6;
    bus_start();
    strap_i = 3'd2;
    send_byte(8'h4C, ack);
    chk(ack == 1'b1, "R9 captured strap matches", ack, 1);
    send_byte(8'h5C, ack);
    exp_port = 8'h5C;
    chk(port_o == exp_port, "R9 write lands", port_o, exp_port);
    bus_stop();

    // R10: one-clock SDA glitch while idle is not a START
    strap_i = 3'd0;
    wq(Q);
    sda_m = 1'b0; wq(1);
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b0; wq(Q);
    send_byte(8'h40, ack);
    chk(ack == 1'b0, "R10 glitch ignored", ack, 0);
    send_byte(8'h00, ack);
    chk(port_o == exp_port, "R10 port unchanged", port_o, exp_port);
    bus_stop();

    // R1: asynchronous reset mid-life restores 0xFF
    rst_n = 1'b0; wq(2);
    chk(port_o == 8'hFF, "R1 reset again", port_o, 8'hFF);
    rst_n = 1'b1; wq(5);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule